// File: doc/BRIEF.md
# CAN Acceptance Filter Bank Array

This block sits behind a CAN receiver and decides whether a received 32-bit identifier word is kept. It holds a set of programmable filter banks. Each bank has two 32-bit filter registers, a mode bit and an enable bit. A bank in mask mode uses its first register as the expected identifier and its second as a bit-select mask. A bank in list mode treats both registers as exact identifiers. When the receiver presents a word with a strobe, every enabled bank is compared against it in parallel. One clock later the block reports whether any bank matched and which filter slot won.

A simple single-cycle register bus gives access to the filter registers and to three control words: a global init flag, the per-bank mode bits and the per-bank enable bits. While a bank is enabled its filter registers are locked against writes. Setting the global init flag lifts that lock, so software can reprogram live banks and then release the flag.

Top module: `acc_filter_array`

## Requirements
- R1: After reset every filter register, the mode word, the enable word and the init flag read as zero, and out_valid and out_accept are low.
- R2: Filter register `slot` of bank `b` sits at bus address 2*b+slot (slot 0 is the identifier/first register, slot 1 the mask/second register). All 32 bits are written by a bus write and read back unchanged.
- R3: A write to a filter register of bank b is ignored when enable bit b is 1 and the init flag is 0. It takes effect when enable bit b is 0 or the init flag is 1.
- R4: A bank in mask mode (mode bit 0) matches when, at every bit position where the second register holds 1, the incoming word equals the first register. Positions where the mask holds 0 are ignored.
- R5: A bank in list mode (mode bit 1) matches when the incoming word equals the first register (slot 0) or the second register (slot 1).
- R6: A bank whose enable bit is 0 never matches, whatever its registers hold.
- R7: When several banks match, the lowest-numbered bank wins. In a list-mode bank that matches through both registers, slot 0 wins.
- R8: out_index equals 2*bank+slot of the winning filter, with slot 0 for a mask-mode bank. When nothing matches, out_accept is 0 and out_index is 0.
- R9: out_valid, out_accept and out_index are registered. They appear on the clock edge after id_valid is sampled high. out_valid is high for exactly one cycle per strobe, and it is low with out_accept low in any cycle that follows one without a strobe.
- R10: With the default 6-bit address, address 32 bit 0 is the init flag, address 33 holds mode bits (bit b for bank b) and address 34 holds enable bits. These control words are always writable and read back. Other bits and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for write and read |
| bus_wdata | input | FILT_W | Write data |
| bus_rdata | output | FILT_W | Read data for bus_addr (combinational) |
| id_valid | input | 1 | Incoming identifier strobe |
| id_word | input | FILT_W | Incoming identifier word |
| out_valid | output | 1 | Result pulse, one cycle after id_valid |
| out_accept | output | 1 | Some enabled bank matched |
| out_index | output | IDX_W | 2*bank+slot of the winning filter |

## Verification
The bench builds the block with its default values: 14 banks, 32-bit filter words and a 6-bit address. At this size all 28 filter registers and all three control words can be swept on the bus, and the lock can be exercised on a live bank both with and without the init flag. Random bank configurations mix modes and enables. Each is probed with identifiers derived from the stored values: mask-mode words with don't-care bits flipped, exact list entries, and unrelated words. Expected results come from a bit-by-bit reference model in the bench. Directed cases pin down priority between overlapping banks and between the two slots of one list bank.

// File: rtl/acc_filter_pkg.sv
package acc_filter_pkg;
  localparam int unsigned FILT_W = 32;

  typedef enum logic {
    MODE_MASK = 1'b0,
    MODE_LIST = 1'b1
  } bank_mode_e;

  typedef struct packed {
    logic hit0;
    logic hit1;
  } bank_hit_t;

  // Mask mode: every selected bit must agree with the identifier register.
  function automatic logic masked_equal(logic [FILT_W-1:0] word,
                                        logic [FILT_W-1:0] ident,
                                        logic [FILT_W-1:0] mask);
    return ((word ^ ident) & mask) == '0;
  endfunction

  function automatic bank_hit_t bank_eval(logic [FILT_W-1:0] word,
                                          logic [FILT_W-1:0] reg0,
                                          logic [FILT_W-1:0] reg1,
                                          bank_mode_e        mode,
                                          logic              enable);
    bank_hit_t h;
    h = '0;
    if (enable) begin
      if (mode == MODE_MASK) begin
        h.hit0 = masked_equal(word, reg0, reg1);
      end else begin
        h.hit0 = (word == reg0);
        h.hit1 = (word == reg1);
      end
    end
    return h;
  endfunction
endpackage

// File: rtl/acc_filter_regs.sv
module acc_filter_regs
  import acc_filter_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 14,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [FILT_W-1:0]                    wdata,
  output logic [FILT_W-1:0]                    rdata,
  output logic [NUM_BANKS-1:0][FILT_W-1:0]     reg0_q,
  output logic [NUM_BANKS-1:0][FILT_W-1:0]     reg1_q,
  output logic [NUM_BANKS-1:0]                 mode_q,
  output logic [NUM_BANKS-1:0]                 enable_q
);
  localparam int unsigned NUM_REGS = 2 * NUM_BANKS;
  localparam logic [ADDR_W-1:0] A_INIT   = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] A_MODE   = A_INIT | ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ENABLE = A_INIT | ADDR_W'(2);
  localparam logic [ADDR_W-2:0] REG_LIMIT = (ADDR_W-1)'(NUM_REGS);

  logic [NUM_REGS-1:0][FILT_W-1:0] filt_q;
  logic                            init_q;
  logic                            filt_sel;
  logic [NUM_BANKS-1:0]            bank_locked;

  assign filt_sel    = !addr[ADDR_W-1] && (addr[ADDR_W-2:0] < REG_LIMIT);
  assign bank_locked = enable_q & {NUM_BANKS{~init_q}};

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic wr_hit;
    logic wr_blocked;
    logic wr_ok;
    assign wr_hit     = wr_en && filt_sel && (addr[ADDR_W-2:0] == (ADDR_W-1)'(k));
    assign wr_blocked = wr_hit && bank_locked[k/2];
    assign wr_ok      = wr_hit && !bank_locked[k/2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) filt_q[k] <= '0;
      else if (wr_ok) filt_q[k] <= wdata;
    end

    // R3
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_blocked |=> $stable(filt_q[k]));
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_out
    assign reg0_q[b] = filt_q[2*b];
    assign reg1_q[b] = filt_q[2*b+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q   <= 1'b0;
      mode_q   <= '0;
      enable_q <= '0;
    end else if (wr_en) begin
      if (addr == A_INIT)   init_q   <= wdata[0];
      if (addr == A_MODE)   mode_q   <= wdata[NUM_BANKS-1:0];
      if (addr == A_ENABLE) enable_q <= wdata[NUM_BANKS-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (filt_sel) begin
      rdata = filt_q[addr[ADDR_W-2:0]];
    end else if (addr == A_INIT) begin
      rdata[0] = init_q;
    end else if (addr == A_MODE) begin
      rdata[NUM_BANKS-1:0] = mode_q;
    end else if (addr == A_ENABLE) begin
      rdata[NUM_BANKS-1:0] = enable_q;
    end
  end

  // R10
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ENABLE) |=> (enable_q == $past(wdata[NUM_BANKS-1:0])));
endmodule

// File: rtl/acc_filter_match.sv
module acc_filter_match
  import acc_filter_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 14
) (
  input  logic [FILT_W-1:0]                word,
  input  logic [NUM_BANKS-1:0][FILT_W-1:0] reg0,
  input  logic [NUM_BANKS-1:0][FILT_W-1:0] reg1,
  input  logic [NUM_BANKS-1:0]             mode,
  input  logic [NUM_BANKS-1:0]             enable,
  output logic [NUM_BANKS-1:0]             hit0,
  output logic [NUM_BANKS-1:0]             hit1
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
    bank_hit_t h;
    assign h       = bank_eval(word, reg0[b], reg1[b], bank_mode_e'(mode[b]), enable[b]);
    assign hit0[b] = h.hit0;
    assign hit1[b] = h.hit1;
  end
endmodule

// File: rtl/acc_filter_prio.sv
module acc_filter_prio #(
  parameter int unsigned NUM_BANKS = 14,
  parameter int unsigned IDX_W     = $clog2(2 * NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe,
  input  logic [NUM_BANKS-1:0] hit0,
  input  logic [NUM_BANKS-1:0] hit1,
  output logic                 out_valid,
  output logic                 out_accept,
  output logic [IDX_W-1:0]     out_index
);
  logic             any_hit;
  logic [IDX_W-1:0] pick_idx;

  assign any_hit = |{hit0, hit1};

  // Scan downward so the lowest bank, and slot 0 within it, is applied last.
  always_comb begin
    pick_idx = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (hit1[b]) pick_idx = IDX_W'(2 * b + 1);
      if (hit0[b]) pick_idx = IDX_W'(2 * b);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_accept <= 1'b0;
      out_index  <= '0;
    end else begin
      out_valid  <= strobe;
      out_accept <= strobe && any_hit;
      out_index  <= (strobe && any_hit) ? pick_idx : '0;
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> out_valid);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> (!out_valid && !out_accept));
  // R8
  reject_zero_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_accept) |-> (out_index == '0));
  // R7
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && hit0[0]) |=> (out_accept && out_index == '0));
endmodule

// File: rtl/acc_filter_array.sv
module acc_filter_array
  import acc_filter_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 14,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned IDX_W     = $clog2(2 * NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [FILT_W-1:0] bus_wdata,
  output logic [FILT_W-1:0] bus_rdata,
  input  logic              id_valid,
  input  logic [FILT_W-1:0] id_word,
  output logic              out_valid,
  output logic              out_accept,
  output logic [IDX_W-1:0]  out_index
);
  logic [NUM_BANKS-1:0][FILT_W-1:0] reg0_q;
  logic [NUM_BANKS-1:0][FILT_W-1:0] reg1_q;
  logic [NUM_BANKS-1:0]             mode_q;
  logic [NUM_BANKS-1:0]             enable_q;
  logic [NUM_BANKS-1:0]             hit0;
  logic [NUM_BANKS-1:0]             hit1;

  acc_filter_regs #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .reg0_q   (reg0_q),
    .reg1_q   (reg1_q),
    .mode_q   (mode_q),
    .enable_q (enable_q)
  );

  acc_filter_match #(.NUM_BANKS(NUM_BANKS)) u_match (
    .word   (id_word),
    .reg0   (reg0_q),
    .reg1   (reg1_q),
    .mode   (mode_q),
    .enable (enable_q),
    .hit0   (hit0),
    .hit1   (hit1)
  );

  acc_filter_prio #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_prio (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (id_valid),
    .hit0       (hit0),
    .hit1       (hit1),
    .out_valid  (out_valid),
    .out_accept (out_accept),
    .out_index  (out_index)
  );

  // R6
  disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && enable_q == '0) |=> !out_accept);
  // R6
  hits_need_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit0 | hit1) & ~enable_q) == '0);
  // R5
  mask_slot1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit1 & ~mode_q) == '0);
endmodule

// File: tb/acc_filter_array_bench.sv
module acc_filter_array_bench;
  localparam int NB = 14;
  localparam int AW = 6;
  localparam int IW = $clog2(2 * NB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          id_valid = 1'b0;
  logic [31:0]   id_word = '0;
  logic          out_valid;
  logic          out_accept;
  logic [IW-1:0] out_index;

  int nchecks = 0;
  int nerr = 0;
  bit finished = 0;

  logic [31:0] m_r0 [NB];
  logic [31:0] m_r1 [NB];
  logic [NB-1:0] m_mode = '0;
  logic [NB-1:0] m_en = '0;
  logic m_init = 1'b0;
  logic [31:0] rs = 32'h1234_5678;

  always #5 clk = ~clk;

  acc_filter_array u_acc_filter_array (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .id_valid(id_valid),
    .id_word(id_word), .out_valid(out_valid), .out_accept(out_accept),
    .out_index(out_index)
  );

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  // Reference model: returns 2*bank+slot or -1.
  function automatic int predict(logic [31:0] w);
    for (int b = 0; b < NB; b++) begin
      if (m_en[b]) begin
        if (!m_mode[b]) begin
          bit ok = 1;
          for (int i = 0; i < 32; i++)
            if (m_r1[b][i] && (w[i] != m_r0[b][i])) ok = 0;
          if (ok) return 2 * b;
        end else begin
          if (w == m_r0[b]) return 2 * b;
          if (w == m_r1[b]) return 2 * b + 1;
        end
      end
    end
    return -1;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a < 2 * NB) begin
      if (!(m_en[a/2] && !m_init)) begin
        if (a % 2 == 0) m_r0[a/2] = d; else m_r1[a/2] = d;
      end
    end else if (a == 32) m_init = d[0];
    else if (a == 33) m_mode = d[NB-1:0];
    else if (a == 34) m_en = d[NB-1:0];
  endtask

  task automatic bus_read(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    #1 d = bus_rdata;
  endtask

  task automatic probe(logic [31:0] w, string tag);
    int e;
    @(negedge clk);
    id_valid = 1'b1; id_word = w;
    @(negedge clk);
    id_valid = 1'b0;
    e = predict(w);
    chk({tag, " R9 valid"}, 64'(out_valid), 64'd1);
    chk({tag, " accept"}, 64'(out_accept), 64'(e >= 0));
    chk({tag, " R8 index"}, 64'(out_index), (e >= 0) ? 64'(e) : 64'd0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int b = 0; b < NB; b++) begin m_r0[b] = '0; m_r1[b] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 out_accept", 64'(out_accept), 64'd0);
    for (int a = 0; a < 2 * NB; a++) begin
      bus_read(a, d); chk("R1 filter reg", 64'(d), 64'd0);
    end
    for (int a = 32; a < 35; a++) begin
      bus_read(a, d); chk("R1 ctrl reg", 64'(d), 64'd0);
    end
    // R6: zero mask would match anything, but no bank is enabled
    probe(32'hCAFE_0001, "R6 reset disabled");
    @(negedge clk);
    chk("R9 idle after pulse", 64'({out_valid, out_accept}), 64'd0);

    // R2: full register sweep
    for (int a = 0; a < 2 * NB; a++) bus_write(a, 32'hA55A_0000 ^ (32'h0101_0101 * a) ^ 32'h8000_0001);
    for (int a = 0; a < 2 * NB; a++) begin
      bus_read(a, d);
      chk("R2 readback", 64'(d), 64'(32'hA55A_0000 ^ (32'h0101_0101 * a) ^ 32'h8000_0001));
    end

    // R10: control words and unmapped addresses
    bus_write(33, 32'hFFFF_2AAA);
    bus_read(33, d); chk("R10 mode word", 64'(d), 64'h2AAA);
    bus_write(33, 32'h0);
    bus_write(32, 32'hFFFF_FFFF);
    bus_read(32, d); chk("R10 init word", 64'(d), 64'h1);
    bus_write(32, 32'h0);
    bus_read(40, d); chk("R10 unmapped", 64'(d), 64'h0);
    bus_read(30, d); chk("R10 unused filter addr", 64'(d), 64'h0);

    // R3: write lock on an enabled bank
    bus_write(34, 32'h0000_0008);
    bus_read(34, d); chk("R10 enable word", 64'(d), 64'h8);
    bus_write(6, 32'h1111_2222);
    bus_read(6, d); chk("R3 locked write ignored", 64'(d), 64'(32'hA55A_0000 ^ (32'h0101_0101 * 6) ^ 32'h8000_0001));
    bus_write(8, 32'h3333_4444);
    bus_read(8, d); chk("R3 unlocked bank written", 64'(d), 64'h3333_4444);
    bus_write(32, 32'h1);
    bus_write(7, 32'h5555_6666);
    bus_read(7, d); chk("R3 init lifts lock", 64'(d), 64'h5555_6666);
    bus_write(32, 32'h0);

    // R7 / R4: overlapping mask banks
    bus_write(32, 32'h1);
    bus_write(4, 32'h0000_0100); bus_write(5, 32'h0000_0F00);
    bus_write(10, 32'h0000_0100); bus_write(11, 32'h0000_0100);
    bus_write(33, 32'h0);
    bus_write(34, 32'h0000_0024);
    bus_write(32, 32'h0);
    probe(32'h0000_0123, "R7 both match");
    chk("R7 lowest bank index", 64'(out_index), 64'd4);
    probe(32'h0000_0300, "R4 upper bank only");
    chk("R4 mask bit excluded index", 64'(out_index), 64'd10);
    probe(32'h0000_0000, "R4 mismatch");
    chk("R4 reject", 64'(out_accept), 64'd0);

    // R5 / R7: list bank with both entries equal, then slot 1
    bus_write(32, 32'h1);
    bus_write(14, 32'h0000_DEAD); bus_write(15, 32'h0000_DEAD);
    bus_write(33, 32'h0000_0080);
    bus_write(34, 32'h0000_0080);
    bus_write(32, 32'h0);
    probe(32'h0000_DEAD, "R7 list slot0 first");
    chk("R7 slot0 index", 64'(out_index), 64'd14);
    bus_write(34, 32'h0);
    bus_write(15, 32'h0BAD_F00D);
    bus_write(34, 32'h0000_0080);
    probe(32'h0BAD_F00D, "R5 list slot1");
    chk("R5 slot1 index", 64'(out_index), 64'd15);
    probe(32'h0BAD_F00C, "R5 list near miss");

    // R4 R5 R6 R7 R8: random configurations
    for (int r = 0; r < 20; r++) begin
      bus_write(32, 32'h1);
      for (int b = 0; b < NB; b++) begin
        logic [31:0] a0, a1;
        a0 = rnd();
        a1 = (r % 2 == 0) ? (rnd() & rnd() & rnd()) : rnd();
        bus_write(2 * b, a0);
        bus_write(2 * b + 1, a1);
      end
      bus_write(33, rnd());
      bus_write(34, rnd());
      bus_write(32, 32'h0);
      for (int p = 0; p < 40; p++) begin
        int b;
        int kind;
        logic [31:0] w;
        b = int'(rnd() % NB);
        kind = int'(rnd() % 3);
        if (kind == 0) w = m_r0[b] ^ (rnd() & ~m_r1[b]);
        else if (kind == 1) w = m_r1[b];
        else w = rnd();
        probe(w, "R4 R5 R6 R8 random");
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule